// File: doc/BRIEF.md
# Windowed Cache Event Counters

This block gathers access statistics for a group of cache banks. Each bank can present one event per cycle. An event carries a 3-bit access-type code and a 3-bit outcome code. The block sorts every event by access class (read, write or neither) and by outcome (hit, miss, pending hit, reservation failure). It keeps two sets of counters for each bank. A per-window set is cleared at every window-end strobe. A cumulative set runs on from reset.

When the window-end strobe is raised, the per-window counts of every bank are captured on a report bus and a valid pulse is given. The same edge also captures a saturating field-by-field sum of all banks. The window counters then start again from zero. A monitoring agent samples the report buses on the valid pulse to build a per-window profile of cache behaviour.

Each report holds nine fields of `CW` bits. Field k sits at bits `[k*CW +: CW]`, with these indices: 0 total accesses, 1 read hits, 2 read misses, 3 read pending hits, 4 read reservation failures, 5 write hits, 6 write misses, 7 write pending hits, 8 write reservation failures. Bank b's report occupies bits `[b*9*CW +: 9*CW]` of the per-bank buses.

Top module: `cache_window_stats`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every report, sum and cumulative field is zero, `rpt_valid` is low and `code_err` is zero.
- R2: The total access field (index 0) counts outcomes hit (0), hit-on-reserved (1), miss (2) and sector miss (4) for every valid access type (0 to 6). Reservation failure (3) does not count as an access.
- R3: Access types global read (0), constant read (2) and instruction read (3) update the read fields (1 to 4). Global write (1) updates the write fields (5 to 8). Types 4 to 6 update neither the read fields nor the write fields.
- R4: Outcomes miss (2) and sector miss (4) both increment the miss field of the event's class.
- R5: Hit-on-reserved and reservation failure increment their own pending-hit and reservation-failure fields of the event's class. They do not touch the hit or miss fields.
- R6: After a clock edge with `win_end` high, `rpt_valid` is high for exactly that cycle. The report buses then carry the window counts from before that edge, and the window counters restart from zero. The reports hold their values until the next `win_end`.
- R7: An event presented in the same cycle as `win_end` is left out of the report being taken and counted in the new window.
- R8: The cumulative fields are never cleared by `win_end`. They only grow, until reset.
- R9: `rpt_sum` carries the field-by-field sum of all banks' reports, captured on the same edge, and saturates at the all-ones value.
- R10: Every counter saturates at all ones instead of wrapping.
- R11: An event with access type 7 or an outcome code from 5 to 7 sets that bank's bit of `code_err` and changes no counter. The bit stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | NB | One event-present bit per bank |
| ev_type | input | 3*NB | Access-type code per bank, bank b at [3b+:3] |
| ev_outcome | input | 3*NB | Outcome code per bank, bank b at [3b+:3] |
| win_end | input | 1 | Window-end strobe |
| rpt_valid | output | 1 | One-cycle pulse marking a new report |
| rpt_bank | output | NB*9*CW | Per-bank report of the last window |
| rpt_sum | output | 9*CW | Saturating sum of the bank reports |
| cum_bank | output | NB*9*CW | Per-bank cumulative counters |
| code_err | output | NB | Sticky per-bank illegal-code flag |

## Verification
An event steered to the wrong class or outcome field shows up at the cumulative outputs on the very next cycle. It also shows up in the next report. A window that fails to clear, or that captures an event from its boundary cycle, shows up as an off-by-one count in the report right after that strobe. An adder or saturation fault shows as a sum field that differs from the bank fields of the same report. A wrapped counter shows as a small value where the saturated maximum is expected.

// File: rtl/cache_window_stats.sv
module cache_window_stats #(
  parameter int NB = 2,
  parameter int CW = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NB-1:0]         ev_valid,
  input  logic [3*NB-1:0]       ev_type,
  input  logic [3*NB-1:0]       ev_outcome,
  input  logic                  win_end,
  output logic                  rpt_valid,
  output logic [NB*9*CW-1:0]    rpt_bank,
  output logic [9*CW-1:0]       rpt_sum,
  output logic [NB*9*CW-1:0]    cum_bank,
  output logic [NB-1:0]         code_err
);
  localparam int NF = 9;
  localparam int RW = NF * CW;
  localparam logic [CW-1:0] MAXV = '1;
  localparam logic [CW-1:0] ONE  = 1;

  logic [NB*RW-1:0] win_all;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [2:0]    ty, oc;
    logic          legal, take;
    logic          is_rd, is_wr, o_hit, o_pend, o_miss, o_fail, o_acc;
    logic [NF-1:0] inc;
    logic [RW-1:0] win_q, cum_q, rpt_q;
    logic          err_q;

    assign ty     = ev_type[3*b +: 3];
    assign oc     = ev_outcome[3*b +: 3];
    assign legal  = (ty != 3'd7) && (oc <= 3'd4);
    assign take   = ev_valid[b] && legal;
    assign is_rd  = (ty == 3'd0) || (ty == 3'd2) || (ty == 3'd3);
    assign is_wr  = (ty == 3'd1);
    assign o_hit  = (oc == 3'd0);
    assign o_pend = (oc == 3'd1);
    assign o_miss = (oc == 3'd2) || (oc == 3'd4);
    assign o_fail = (oc == 3'd3);
    assign o_acc  = !o_fail;

    assign inc = take ? {is_wr & o_fail, is_wr & o_pend, is_wr & o_miss, is_wr & o_hit,
                         is_rd & o_fail, is_rd & o_pend, is_rd & o_miss, is_rd & o_hit,
                         o_acc} : '0;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        win_q <= '0;
        cum_q <= '0;
        rpt_q <= '0;
        err_q <= 1'b0;
      end else begin
        if (ev_valid[b] && !legal) err_q <= 1'b1;
        if (win_end) rpt_q <= win_q;
        for (int f = 0; f < NF; f++) begin
          if (win_end)
            win_q[f*CW +: CW] <= inc[f] ? ONE : '0;
          else if (inc[f] && win_q[f*CW +: CW] != MAXV)
            win_q[f*CW +: CW] <= win_q[f*CW +: CW] + ONE;
          if (inc[f] && cum_q[f*CW +: CW] != MAXV)
            cum_q[f*CW +: CW] <= cum_q[f*CW +: CW] + ONE;
        end
      end
    end

    assign win_all[b*RW +: RW]  = win_q;
    assign rpt_bank[b*RW +: RW] = rpt_q;
    assign cum_bank[b*RW +: RW] = cum_q;
    assign code_err[b]          = err_q;
  end

  logic [RW-1:0] sum_d;

  always_comb begin
    for (int f = 0; f < NF; f++) begin
      logic [CW:0] acc;
      acc = '0;
      for (int b = 0; b < NB; b++) begin
        acc = acc + {1'b0, win_all[b*RW + f*CW +: CW]};
        if (acc[CW]) acc = {1'b0, MAXV};
      end
      sum_d[f*CW +: CW] = acc[CW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rpt_valid <= 1'b0;
      rpt_sum   <= '0;
    end else begin
      rpt_valid <= win_end;
      if (win_end) rpt_sum <= sum_d;
    end
  end
endmodule

module cache_window_stats_chk #(
  parameter int NB = 2,
  parameter int CW = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               win_end,
  input logic               rpt_valid,
  input logic [NB*9*CW-1:0] rpt_bank,
  input logic [9*CW-1:0]    rpt_sum,
  input logic [NB*9*CW-1:0] cum_bank,
  input logic [NB-1:0]      code_err
);
  // R6
  rpt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> rpt_valid);
  // R6
  rpt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> !rpt_valid);
  // R6
  rpt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> ($stable(rpt_bank) && $stable(rpt_sum)));
  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((code_err & $past(code_err)) == $past(code_err)));
  // R8
  cum_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cum_bank[CW-1:0] >= $past(cum_bank[CW-1:0])));
  // R9
  sum_ge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |-> (rpt_sum[CW-1:0] >= rpt_bank[CW-1:0]));
endmodule

bind cache_window_stats cache_window_stats_chk #(.NB(NB), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .win_end(win_end), .rpt_valid(rpt_valid),
  .rpt_bank(rpt_bank), .rpt_sum(rpt_sum), .cum_bank(cum_bank), .code_err(code_err)
);

// File: tb/tb_cache_window_stats.sv
module tb_cache_window_stats;
  localparam int TCLK = 10;
  localparam int NB = 2;
  localparam int CW = 8;
  localparam int RW = 9 * CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB-1:0] ev_valid = '0;
  logic [3*NB-1:0] ev_type = '0;
  logic [3*NB-1:0] ev_outcome = '0;
  logic win_end = 1'b0;
  logic rpt_valid;
  logic [NB*RW-1:0] rpt_bank, cum_bank;
  logic [RW-1:0] rpt_sum;
  logic [NB-1:0] code_err;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(TCLK/2) clk = ~clk;

  cache_window_stats #(.NB(NB), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_type(ev_type),
    .ev_outcome(ev_outcome), .win_end(win_end), .rpt_valid(rpt_valid),
    .rpt_bank(rpt_bank), .rpt_sum(rpt_sum), .cum_bank(cum_bank), .code_err(code_err)
  );

  function automatic int rb(int b, int f); return int'(rpt_bank[b*RW + f*CW +: CW]); endfunction
  function automatic int cb(int b, int f); return int'(cum_bank[b*RW + f*CW +: CW]); endfunction
  function automatic int sm(int f); return int'(rpt_sum[f*CW +: CW]); endfunction

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_ev(int b, int ty, int oc);
    ev_valid[b] = 1'b1;
    ev_type[3*b +: 3] = 3'(ty);
    ev_outcome[3*b +: 3] = 3'(oc);
  endtask

  task automatic step;
    @(negedge clk);
    ev_valid = '0;
    win_end = 1'b0;
  endtask

  task automatic one_ev(int b, int ty, int oc);
    set_ev(b, ty, oc);
    step();
  endtask

  task automatic strobe;
    win_end = 1'b1;
    step();
  endtask

  task automatic t_reset;
    int nz = 0;
    nz = (rpt_bank != '0) + (rpt_sum != '0) + (cum_bank != '0);
    chk("R1 zero outputs", nz, 0);
    chk("R1 rpt_valid", int'(rpt_valid), 0);
    chk("R1 code_err", int'(code_err), 0);
  endtask

  task automatic t_classify;
    one_ev(0, 0, 0); one_ev(0, 2, 2); one_ev(0, 3, 4); one_ev(0, 0, 1);
    one_ev(0, 0, 3); one_ev(0, 1, 0); one_ev(0, 1, 2); one_ev(0, 1, 1);
    one_ev(0, 1, 3); one_ev(0, 5, 0);
    chk("R8 cum acc before strobe", cb(0, 0), 8);
    strobe();
    chk("R6 rpt_valid pulse", int'(rpt_valid), 1);
    chk("R2 access total", rb(0, 0), 8);
    chk("R3 read hit", rb(0, 1), 1);
    chk("R4 read miss+sector miss", rb(0, 2), 2);
    chk("R5 read pending", rb(0, 3), 1);
    chk("R5 read rfail", rb(0, 4), 1);
    chk("R3 write hit", rb(0, 5), 1);
    chk("R4 write miss", rb(0, 6), 1);
    chk("R5 write pending", rb(0, 7), 1);
    chk("R5 write rfail", rb(0, 8), 1);
    step();
    chk("R6 pulse one cycle", int'(rpt_valid), 0);
    chk("R6 report held", rb(0, 0), 8);
    strobe();
    chk("R6 window cleared", rb(0, 0) + rb(0, 2) + rb(0, 8), 0);
    chk("R8 cum survives strobe", cb(0, 0), 8);
    chk("R8 cum read miss", cb(0, 2), 2);
  endtask

  task automatic t_boundary;
    set_ev(0, 1, 0);
    win_end = 1'b1;
    step();
    chk("R7 boundary event excluded", rb(0, 5), 0);
    strobe();
    chk("R7 boundary event in new window", rb(0, 5), 1);
    chk("R7 new window access", rb(0, 0), 1);
  endtask

  task automatic t_sum;
    set_ev(0, 0, 2); set_ev(1, 2, 2); step();
    set_ev(0, 3, 4); set_ev(1, 0, 2); step();
    one_ev(1, 0, 4);
    one_ev(1, 1, 3);
    strobe();
    chk("R9 bank0 read miss", rb(0, 2), 2);
    chk("R9 bank1 read miss", rb(1, 2), 3);
    chk("R9 sum read miss", sm(2), 5);
    chk("R9 sum access", sm(0), 5);
    chk("R9 sum write rfail", sm(8), 1);
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 300; i++) begin
      set_ev(0, 0, 0); set_ev(1, 0, 0); step();
    end
    chk("R10 cum saturates", cb(1, 1), 255);
    strobe();
    chk("R10 window saturates", rb(1, 1), 255);
    chk("R10 window access saturates", rb(0, 0), 255);
    chk("R9 sum saturates", sm(1), 255);
  endtask

  task automatic t_err;
    logic [NB*RW-1:0] snap;
    snap = cum_bank;
    set_ev(0, 7, 0); set_ev(1, 0, 6); step();
    chk("R11 err flags", int'(code_err), 3);
    chk("R11 cum unchanged", int'(cum_bank == snap), 1);
    strobe();
    chk("R11 window untouched", int'(rpt_bank == '0), 1);
    one_ev(0, 0, 0);
    chk("R11 err sticky", int'(code_err), 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_classify();
    t_boundary();
    t_sum();
    t_saturate();
    t_err();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(TCLK * 100000);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule